// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Sequencer

This block drives a single DRAM bank under an open-page policy. A request names a row, a column and a direction. The block compares the row against the row currently latched in the bank's sense amplifiers and sorts the request into one of three cases:

- **Hit:** the row is already open, so only the column access is issued.
- **Empty:** the bank is precharged, so the row is opened and then the column access is issued.
- **Conflict:** a different row is open, so the bank is closed, the new row is opened, and then the column access is issued.

After every access the row stays open.

Three programmable gaps hold back command issue:

- activate to column (`t_rcd_i`)
- precharge to activate (`t_rp_i`)
- activate to precharge (`t_ras_i`)

Each gap is a minimum number of clock edges between the two commands. A value of 0 or 1 means the next edge is allowed. The block serves one request at a time. Software changes the gap values only while the block is in reset.

Top module: `bank_rowbuf_seq`

## Requirements
- R1: After reset the bank is treated as having no open row. `req_ready_o` is 1, and `cmd_valid_o` and `stat_valid_o` are 0.
- R2: A request to the open row produces only a column command. That command appears in the cycle after the accept edge.
- R3: A request to a closed bank produces ACTIVATE with the row on `cmd_addr_o`, followed by the column command.
- R4: A request to a row other than the open one produces three commands in this order: PRECHARGE with address 0, then ACTIVATE, then the column command.
- R5: A column command issues no earlier than max(1, `t_rcd_i`) edges after the ACTIVATE of its row.
- R6: An ACTIVATE that follows a PRECHARGE issues no earlier than max(1, `t_rp_i`) edges after it.
- R7: A PRECHARGE issues no earlier than max(1, `t_ras_i`) edges after the last ACTIVATE.
- R8: `stat_valid_o` pulses for one cycle in the cycle after a request is accepted. In that cycle `stat_kind_o` reads 0 for a hit, 1 for an empty bank and 2 for a conflict.
- R9: `req_ready_o` drops after an accept and stays low until the request's column command has been issued. It returns high in the same cycle in which the column command is visible.
- R10: `cmd_op_o` encodes commands as 0 = ACTIVATE, 1 = READ, 2 = WRITE, 3 = PRECHARGE. READ or WRITE is chosen by `req_we_i`, and the column command carries the column on `cmd_addr_o`.
- R11: Every command is a single-cycle `cmd_valid_o` pulse, and no command is issued while waiting on a gap or while idle. A gap value of zero behaves as a gap of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_we_i | input | 1 | 1 = write, 0 = read |
| t_rcd_i | input | TW | Activate-to-column gap |
| t_rp_i | input | TW | Precharge-to-activate gap |
| t_ras_i | input | TW | Activate-to-precharge gap |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_op_o | output | 2 | Command type |
| cmd_addr_o | output | max(ROW_W,COL_W) | Row for ACTIVATE, column for READ/WRITE, 0 for PRECHARGE |
| stat_valid_o | output | 1 | Classification strobe |
| stat_kind_o | output | 2 | Hit, empty or conflict |

## Verification
The status pulse is due one edge after the accept edge.

Each command is due on a specific edge:

- The first command is due at the later of the accept edge plus one and the earliest edge its gap allows.
- Each following command is due exactly max(1, gap) edges after the one before it.

The bench keeps its own edge count and its own deadlines for the three gaps, and from them computes the exact edge of each expected command. It then samples on every falling edge between the accept and the column command, so that an early command, a late command and a missing command each fail at a known cycle. Every combination of small gap values is swept, with a reset before each combination, so every request sequence starts from a known closed bank.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_EMPTY    = 2'd1,
    KIND_CONFLICT = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL
  } seq_state_e;

  // gap timer slots
  localparam int GAP_RCD = 0;
  localparam int GAP_RP  = 1;
  localparam int GAP_RAS = 2;
  localparam int NUM_GAPS = 3;
endpackage

// File: rtl/rowbuf_gap_timer.sv
module rowbuf_gap_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] gap_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  // load gap-1 so the dependent command may fire gap edges later (min 1)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (gap_i > TW'(1)) ? gap_i - TW'(1) : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rowbuf_row_track.sv
module rowbuf_row_track #(
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             is_open_o,
  output logic [ROW_W-1:0] open_row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_open_o  <= 1'b0;
      open_row_o <= '0;
    end else if (open_i) begin
      is_open_o  <= 1'b1;
      open_row_o <= row_i;
    end else if (close_i) begin
      is_open_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/rowbuf_fsm.sv
module rowbuf_fsm
  import rowbuf_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_we_i,
  output logic             req_ready_o,
  input  logic             is_open_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic             col_ok_i,
  input  logic             act_ok_i,
  input  logic             pre_ok_i,
  output logic             fire_act_o,
  output logic             fire_pre_o,
  output logic [ROW_W-1:0] row_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic             stat_valid_o,
  output logic [1:0]       stat_kind_o
);
  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             we_q;
  logic             accept, fire_col;
  req_kind_e        kind_c;
  cmd_op_e          op_d;
  logic [AW-1:0]    addr_d;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    if (!is_open_i)                    kind_c = KIND_EMPTY;
    else if (open_row_i == req_row_i)  kind_c = KIND_HIT;
    else                               kind_c = KIND_CONFLICT;
  end

  assign fire_pre_o = (state_q == ST_PRE) && pre_ok_i;
  assign fire_act_o = (state_q == ST_ACT) && act_ok_i;
  assign fire_col   = (state_q == ST_COL) && col_ok_i;
  assign row_o      = row_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        unique case (kind_c)
          KIND_HIT:   state_d = ST_COL;
          KIND_EMPTY: state_d = ST_ACT;
          default:    state_d = ST_PRE;
        endcase
      end
      ST_PRE:  if (fire_pre_o) state_d = ST_ACT;
      ST_ACT:  if (fire_act_o) state_d = ST_COL;
      ST_COL:  if (fire_col)   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_d   = OP_PRE;
    addr_d = '0;
    if (fire_act_o) begin
      op_d   = OP_ACT;
      addr_d = AW'(row_q);
    end else if (fire_col) begin
      op_d   = we_q ? OP_WR : OP_RD;
      addr_d = AW'(col_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      row_q        <= '0;
      col_q        <= '0;
      we_q         <= 1'b0;
      cmd_valid_o  <= 1'b0;
      cmd_op_o     <= '0;
      cmd_addr_o   <= '0;
      stat_valid_o <= 1'b0;
      stat_kind_o  <= '0;
    end else begin
      state_q      <= state_d;
      stat_valid_o <= accept;
      if (accept) begin
        row_q       <= req_row_i;
        col_q       <= req_col_i;
        we_q        <= req_we_i;
        stat_kind_o <= kind_c;
      end
      cmd_valid_o <= fire_pre_o || fire_act_o || fire_col;
      if (fire_pre_o || fire_act_o || fire_col) begin
        cmd_op_o   <= op_d;
        cmd_addr_o <= addr_d;
      end
    end
  end
endmodule

// File: rtl/bank_rowbuf_seq.sv
module bank_rowbuf_seq
  import rowbuf_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  parameter int TW    = 4,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_we_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_ras_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic             stat_valid_o,
  output logic [1:0]       stat_kind_o
);
  logic             fire_act, fire_pre, is_open;
  logic [ROW_W-1:0] open_row, seq_row;
  logic [NUM_GAPS-1:0] gap_load, gap_done;
  logic [TW-1:0]       gap_val [NUM_GAPS];

  assign gap_load[GAP_RCD] = fire_act;
  assign gap_load[GAP_RP]  = fire_pre;
  assign gap_load[GAP_RAS] = fire_act;
  assign gap_val[GAP_RCD]  = t_rcd_i;
  assign gap_val[GAP_RP]   = t_rp_i;
  assign gap_val[GAP_RAS]  = t_ras_i;

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    rowbuf_gap_timer #(.TW(TW)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (gap_load[g]),
      .gap_i  (gap_val[g]),
      .done_o (gap_done[g])
    );
  end

  rowbuf_row_track #(.ROW_W(ROW_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (fire_act),
    .close_i    (fire_pre),
    .row_i      (seq_row),
    .is_open_o  (is_open),
    .open_row_o (open_row)
  );

  rowbuf_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_row_i    (req_row_i),
    .req_col_i    (req_col_i),
    .req_we_i     (req_we_i),
    .req_ready_o  (req_ready_o),
    .is_open_i    (is_open),
    .open_row_i   (open_row),
    .col_ok_i     (gap_done[GAP_RCD]),
    .act_ok_i     (gap_done[GAP_RP]),
    .pre_ok_i     (gap_done[GAP_RAS]),
    .fire_act_o   (fire_act),
    .fire_pre_o   (fire_pre),
    .row_o        (seq_row),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_op_o     (cmd_op_o),
    .cmd_addr_o   (cmd_addr_o),
    .stat_valid_o (stat_valid_o),
    .stat_kind_o  (stat_kind_o)
  );
endmodule

// File: rtl/bank_rowbuf_seq_chk.sv
module bank_rowbuf_seq_chk #(
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  parameter int TW    = 4,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [ROW_W-1:0] req_row_i,
  input logic [COL_W-1:0] req_col_i,
  input logic             req_we_i,
  input logic [TW-1:0]    t_rcd_i,
  input logic [TW-1:0]    t_rp_i,
  input logic [TW-1:0]    t_ras_i,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic [AW-1:0]    cmd_addr_o,
  input logic             stat_valid_o,
  input logic [1:0]       stat_kind_o
);
  localparam logic [TW:0] SAT = '1;
  logic [TW:0] since_act, since_pre, need_rcd, need_ras, need_rp;
  logic is_act, is_pre, is_col;

  assign is_act = cmd_valid_o && (cmd_op_o == 2'd0);
  assign is_pre = cmd_valid_o && (cmd_op_o == 2'd3);
  assign is_col = cmd_valid_o && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2);

  function automatic logic [TW:0] eff(input logic [TW-1:0] t);
    return (t == '0) ? (TW+1)'(1) : (TW+1)'(t);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= SAT;
      since_pre <= SAT;
      need_rcd  <= '0;
      need_ras  <= '0;
      need_rp   <= '0;
    end else begin
      if (is_act) begin
        since_act <= (TW+1)'(1);
        need_rcd  <= eff(t_rcd_i);
        need_ras  <= eff(t_ras_i);
      end else if (since_act != SAT) begin
        since_act <= since_act + 1'b1;
      end
      if (is_pre) begin
        since_pre <= (TW+1)'(1);
        need_rp   <= eff(t_rp_i);
      end else if (since_pre != SAT) begin
        since_pre <= since_pre + 1'b1;
      end
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> since_act >= need_rcd) else $error("rcd gap"); // R5
  AST_RP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_pre >= need_rp) else $error("rp gap"); // R6
  AST_RAS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> since_act >= need_ras) else $error("ras gap"); // R7
  AST_STAT_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (stat_valid_o && stat_kind_o != 2'd3)) else $error("stat"); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o) else $error("ready"); // R9
  AST_READY_ON_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> req_ready_o) else $error("ready col"); // R9
  AST_HIT_NEXT_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_kind_o == 2'd0) |=> is_col) else $error("hit"); // R2
  AST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |=> !cmd_valid_o) else $error("pulse"); // R11
endmodule

bind bank_rowbuf_seq bank_rowbuf_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_chk (.*);

// File: tb/sim_bank_rowbuf_seq.sv
module sim_bank_rowbuf_seq;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int TW    = 4;
  localparam int AW    = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [ROW_W-1:0] req_row_i = '0;
  logic [COL_W-1:0] req_col_i = '0;
  logic             req_we_i = 1'b0;
  logic [TW-1:0]    t_rcd_i = '0, t_rp_i = '0, t_ras_i = '0;
  logic             cmd_valid_o;
  logic [1:0]       cmd_op_o;
  logic [AW-1:0]    cmd_addr_o;
  logic             stat_valid_o;
  logic [1:0]       stat_kind_o;

  int checks = 0, errors = 0, ec = 0, wd = 0;
  int col_ok, act_ok, pre_ok;
  bit m_open;
  int m_row;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) ec <= ec + 1;

  bank_rowbuf_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u0 (.*);

  always @(posedge clk_i) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, ec, act, exp);
    end
  endtask

  function automatic int eff(input int t);
    return (t < 1) ? 1 : t;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic do_reset(input int rcd, input int rp, input int ras);
    @(negedge clk_i);
    rst_ni  = 1'b0;
    t_rcd_i = TW'(rcd);
    t_rp_i  = TW'(rp);
    t_ras_i = TW'(ras);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    col_ok = 0; act_ok = 0; pre_ok = 0; m_open = 0; m_row = 0;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready", int'(req_ready_o), 1);
    chk(cmd_valid_o == 1'b0 && stat_valid_o == 1'b0, "R1 idle outputs",
        int'({cmd_valid_o, stat_valid_o}), 0);
  endtask

  task automatic do_req(input int row, input int col, input bit we);
    int a, kind, pre_e, act_e, col_e, exp_op, exp_addr;
    bit exp_v;
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_row_i   = ROW_W'(row);
    req_col_i   = COL_W'(col);
    req_we_i    = we;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    a = ec;
    kind = !m_open ? 1 : (m_row == row ? 0 : 2);
    chk(stat_valid_o == 1'b1 && int'(stat_kind_o) == kind, "R8 status",
        int'({stat_valid_o, stat_kind_o}), 4 + kind);
    chk(req_ready_o == 1'b0, "R9 busy after accept", int'(req_ready_o), 0);
    pre_e = -1; act_e = -1;
    if (kind == 2) begin
      pre_e  = imax(a + 1, pre_ok);
      act_ok = pre_e + eff(int'(t_rp_i));
    end
    if (kind != 0) begin
      act_e  = imax(pre_e < 0 ? a + 1 : pre_e + 1, act_ok);
      col_ok = act_e + eff(int'(t_rcd_i));
      pre_ok = act_e + eff(int'(t_ras_i));
      m_open = 1; m_row = row;
    end
    col_e = imax(act_e < 0 ? a + 1 : act_e + 1, col_ok);
    for (int e = a + 1; e <= col_e; e++) begin
      @(negedge clk_i);
      exp_v = 1'b1; exp_op = 0; exp_addr = 0;
      if (e == pre_e) begin exp_op = 3; exp_addr = 0; end
      else if (e == act_e) begin exp_op = 0; exp_addr = row; end
      else if (e == col_e) begin exp_op = we ? 2 : 1; exp_addr = col; end
      else exp_v = 1'b0;
      if (e == pre_e)
        chk(cmd_valid_o && cmd_op_o == 2'(exp_op), "R4 precharge / R7 ras", int'(cmd_valid_o), 1);
      else if (e == act_e)
        chk(cmd_valid_o && cmd_op_o == 2'(exp_op), kind == 2 ? "R4 activate / R6 rp" : "R3 activate",
            int'(cmd_valid_o), 1);
      else if (e == col_e)
        chk(cmd_valid_o && cmd_op_o == 2'(exp_op), kind == 0 ? "R2 hit column" : "R5 column after rcd",
            int'(cmd_valid_o), 1);
      else
        chk(cmd_valid_o == 1'b0, "R11 no command while waiting", int'(cmd_valid_o), 0);
      if (exp_v)
        chk(int'(cmd_addr_o) == exp_addr && int'(cmd_op_o) == exp_op, "R10 op/addr",
            int'({cmd_op_o, cmd_addr_o}), exp_op * 16 + exp_addr);
      chk(req_ready_o == (e == col_e), "R9 ready timing", int'(req_ready_o), int'(e == col_e));
    end
    @(negedge clk_i);
    chk(cmd_valid_o == 1'b0 && stat_valid_o == 1'b0, "R11 single pulse",
        int'({cmd_valid_o, stat_valid_o}), 0);
  endtask

  initial begin
    for (int rcd = 0; rcd < 4; rcd++)
      for (int rp = 0; rp < 4; rp++)
        for (int ras = 0; ras < 6; ras++) begin
          int b;
          b = (rcd * 24 + rp * 6 + ras) % 16;
          do_reset(rcd, rp, ras);
          do_req(b, 1, 1'b0);              // empty
          do_req((b + 5) % 16, 2, 1'b1);   // conflict right after activate
          do_req((b + 5) % 16, 7, 1'b0);   // hit
          do_req((b + 9) % 16, 0, 1'b1);   // conflict
          do_req((b + 9) % 16, 3, 1'b1);   // hit
          do_req((b + 9) % 16, 5, 1'b0);   // hit
        end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule